// File: doc/BRIEF.md
# Three-Input Integer Adder Unit

This execution unit takes one 64-bit instruction word per accepted transfer together with the operand values the surrounding pipeline has already fetched. It forms the 32-bit sum of three operands and hands back the destination register index, the sum and a write enable, all registered. Operand A and operand C come from register-file read ports. Operand B comes from a register read, a constant-buffer value or a sign-extended immediate held in the instruction word. The form input picks the source of B.

In the register-register form the unit can build a split three-way sum. Each operand can be cut down to its low or high half-word, and the sum of A and B can be moved up or down by 16 bits before C is added. Each operand can be negated on its own in every form. The sum wraps modulo 2^32 and no carry is kept. A false guard predicate, or an illegal half-word select, clears the write enable.

Both edges of the unit are valid/ready streams. An input is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. An output is held unchanged while `out_valid` is high and `out_ready` is low.

Top module: `tri_add_unit`

## Requirements
- R1: While reset is asserted and after it is released with no input, `out_valid` is 0 and `in_ready` is 1.
- R2: In the register-register form (`in_form` = 0), with all height fields 0, mode 0 and no negation, the result is A + B + C modulo 2^32. Here B is `in_opb_reg`.
- R3: Negate flags sit at instruction bit 51 for A, bit 50 for B and bit 49 for C. A set flag replaces that operand by its two's-complement negation, and this is applied after the height selection.
- R4: Height fields sit at bits 36:35 for A, 34:33 for B and 32:31 for C. In the register-register form, a value of 1 keeps the low 16 bits (zero-extended) and 2 keeps the upper 16 bits moved to the low half (zero-extended). A value of 0 keeps the full word.
- R5: The mode field at bits 38:37 acts on the partial sum A+B in the register-register form. A value of 1 shifts it right logically by 16 and 2 shifts it left by 16, before C is added. Values 0 and 3 leave it unchanged.
- R6: In the constant-buffer form (`in_form` = 1) and the immediate form (`in_form` = 2 or 3), the height fields and the mode field have no effect. Operands are full words, and a height value of 3 raises no error.
- R7: `in_form` selects operand B: 0 gives `in_opb_reg`, 1 gives `in_opb_cbuf`, and 2 or 3 give the immediate. The immediate is instruction bits 38:20 as its low 19 bits, with bit 56 as the sign copied into bits 31:19.
- R8: `out_dst` equals instruction bits 7:0 of the accepted word.
- R9: When `in_guard` is 0, `out_wr_en` is 0, while the result and the destination are still delivered.
- R10: In the register-register form, a height field equal to 3 on any operand sets `out_err` to 1 and forces `out_wr_en` to 0.
- R11: An accepted input appears at the output on the next clock edge. While `out_valid` is 1 and `out_ready` is 0, the outputs stay unchanged and `in_ready` is 0. Results leave in the order the inputs were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_instr | input | 64 | Instruction word |
| in_form | input | 2 | Operand-B source: 0 register, 1 constant buffer, 2/3 immediate |
| in_opa | input | 32 | Operand A register value |
| in_opb_reg | input | 32 | Operand B register value |
| in_opb_cbuf | input | 32 | Operand B constant-buffer value |
| in_opc | input | 32 | Operand C register value |
| in_guard | input | 1 | Guard predicate value; 0 suppresses the write |
| out_valid | output | 1 | Result register holds an item |
| out_ready | input | 1 | Consumer takes the item this cycle |
| out_dst | output | 8 | Destination register index |
| out_result | output | 32 | Three-way sum |
| out_wr_en | output | 1 | Register write permitted |
| out_err | output | 1 | Illegal height field seen |

## Verification
The sum is first tried with full-word operands, including values that wrap past 2^32. Next come single negate flags, which separate the sign handling of each operand. Per-operand height selections, some combined with negation, show whether the half-word cut comes before the negation. Each mode value is then applied to the same operands, so the left shift, the right shift and the pass-through cases give different results. The same instruction words with heights and mode set are replayed in the constant-buffer and immediate forms, where any leak of the register-only features changes the sum. Immediates of both signs are used as well. Guard-false inputs, illegal heights on each operand and a randomly stalled consumer show whether the write gating, the error flag and the ordering hold under back-pressure.

// File: rtl/tri_add_pkg.sv
package tri_add_pkg;

  localparam int unsigned INSTR_W = 64;
  localparam int unsigned NUM_OPS = 3;

  typedef enum logic [1:0] {
    FORM_REG  = 2'd0,
    FORM_CBUF = 2'd1,
    FORM_IMM  = 2'd2,
    FORM_IMM2 = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    HGT_FULL = 2'd0,
    HGT_LO   = 2'd1,
    HGT_HI   = 2'd2,
    HGT_BAD  = 2'd3
  } height_e;

  typedef enum logic [1:0] {
    PS_KEEP  = 2'd0,
    PS_SHR   = 2'd1,
    PS_SHL   = 2'd2,
    PS_KEEP2 = 2'd3
  } pshift_e;

  // Field positions inside the instruction word; index 0 = A, 1 = B, 2 = C
  localparam int unsigned DST_LSB   = 0;
  localparam int unsigned DST_W     = 8;
  localparam int unsigned MODE_LSB  = 37;
  localparam int unsigned IMM_LSB   = 20;
  localparam int unsigned IMM_W     = 19;
  localparam int unsigned IMM_SIGN  = 56;
  localparam int unsigned NEG_A_BIT = 51;
  localparam int unsigned HGT_A_LSB = 35;

endpackage

// File: rtl/tri_add_decode.sv
module tri_add_decode
  import tri_add_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [INSTR_W-1:0]          instr,
  input  logic [1:0]                  form,
  input  logic [DATA_W-1:0]           opb_reg,
  input  logic [DATA_W-1:0]           opb_cbuf,
  output logic [DST_W-1:0]            dst,
  output logic                        reg_form,
  output pshift_e                     pshift,
  output logic [NUM_OPS-1:0][1:0]     hgt,
  output logic [NUM_OPS-1:0]          neg,
  output logic [DATA_W-1:0]           opb,
  output logic                        bad_hgt
);

  localparam int unsigned EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  assign dst      = instr[DST_LSB +: DST_W];
  assign reg_form = (form_e'(form) == FORM_REG);
  assign imm_ext  = {{EXT_W{instr[IMM_SIGN]}}, instr[IMM_LSB +: IMM_W]};

  // Height fields step down by two bits per operand, negate flags by one bit
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_fields
    assign hgt[g] = reg_form ? instr[HGT_A_LSB - 2*g +: 2] : 2'(HGT_FULL);
    assign neg[g] = instr[NEG_A_BIT - g];
  end

  assign pshift = reg_form ? pshift_e'(instr[MODE_LSB +: 2]) : PS_KEEP;

  always_comb begin
    unique case (form_e'(form))
      FORM_REG:  opb = opb_reg;
      FORM_CBUF: opb = opb_cbuf;
      default:   opb = imm_ext;
    endcase
  end

  always_comb begin
    bad_hgt = 1'b0;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (height_e'(hgt[i]) == HGT_BAD) bad_hgt = 1'b1;
    end
  end

endmodule

// File: rtl/tri_add_shaper.sv
module tri_add_shaper
  import tri_add_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] val_in,
  input  logic [1:0]        hgt,
  input  logic              neg,
  output logic [DATA_W-1:0] val_out
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] cut;

  always_comb begin
    unique case (height_e'(hgt))
      HGT_LO:  cut = {{HALF_W{1'b0}}, val_in[HALF_W-1:0]};
      HGT_HI:  cut = {{HALF_W{1'b0}}, val_in[DATA_W-1:HALF_W]};
      default: cut = val_in;
    endcase
  end

  // Negation follows the half-word cut
  assign val_out = neg ? (~cut + DATA_W'(1)) : cut;

endmodule

// File: rtl/tri_add_core.sv
module tri_add_core
  import tri_add_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [NUM_OPS-1:0][DATA_W-1:0] ops,
  input  pshift_e                        pshift,
  output logic [DATA_W-1:0]              sum
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] part;
  logic [DATA_W-1:0] moved;

  assign part = ops[0] + ops[1];

  always_comb begin
    unique case (pshift)
      PS_SHR:  moved = part >> HALF_W;
      PS_SHL:  moved = part << HALF_W;
      default: moved = part;
    endcase
  end

  assign sum = moved + ops[2];

endmodule

// File: rtl/tri_add_unit.sv
module tri_add_unit
  import tri_add_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [63:0]         in_instr,
  input  logic [1:0]          in_form,
  input  logic [DATA_W-1:0]   in_opa,
  input  logic [DATA_W-1:0]   in_opb_reg,
  input  logic [DATA_W-1:0]   in_opb_cbuf,
  input  logic [DATA_W-1:0]   in_opc,
  input  logic                in_guard,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [7:0]          out_dst,
  output logic [DATA_W-1:0]   out_result,
  output logic                out_wr_en,
  output logic                out_err
);

  logic [DST_W-1:0]              dec_dst;
  logic                          dec_reg_form;
  pshift_e                       dec_pshift;
  logic [NUM_OPS-1:0][1:0]       dec_hgt;
  logic [NUM_OPS-1:0]            dec_neg;
  logic [DATA_W-1:0]             dec_opb;
  logic                          dec_bad;
  logic [NUM_OPS-1:0][DATA_W-1:0] raw_ops;
  logic [NUM_OPS-1:0][DATA_W-1:0] shaped;
  logic [DATA_W-1:0]             sum;
  logic                          take;

  tri_add_decode #(.DATA_W(DATA_W)) u_dec (
    .instr    (in_instr),
    .form     (in_form),
    .opb_reg  (in_opb_reg),
    .opb_cbuf (in_opb_cbuf),
    .dst      (dec_dst),
    .reg_form (dec_reg_form),
    .pshift   (dec_pshift),
    .hgt      (dec_hgt),
    .neg      (dec_neg),
    .opb      (dec_opb),
    .bad_hgt  (dec_bad)
  );

  assign raw_ops[0] = in_opa;
  assign raw_ops[1] = dec_opb;
  assign raw_ops[2] = in_opc;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_shape
    tri_add_shaper #(.DATA_W(DATA_W)) u_shp (
      .val_in  (raw_ops[g]),
      .hgt     (dec_hgt[g]),
      .neg     (dec_neg[g]),
      .val_out (shaped[g])
    );
  end

  tri_add_core #(.DATA_W(DATA_W)) u_core (
    .ops    (shaped),
    .pshift (dec_pshift),
    .sum    (sum)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_dst    <= '0;
      out_result <= '0;
      out_wr_en  <= 1'b0;
      out_err    <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_dst    <= dec_dst;
        out_result <= sum;
        out_wr_en  <= in_guard && !dec_bad;
        out_err    <= dec_bad;
      end
    end
  end

endmodule

// File: rtl/tri_add_chk.sv
module tri_add_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [63:0]       in_instr,
  input logic [1:0]        in_form,
  input logic              in_guard,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_dst,
  input logic [DATA_W-1:0] out_result,
  input logic              out_wr_en,
  input logic              out_err
);

  logic acc;
  assign acc = in_valid && in_ready;

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_dst)
      && $stable(out_wr_en) && $stable(out_err));

  a_r11_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r8_dst: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_dst == $past(in_instr[7:0]));

  a_r9_guard: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_guard |=> !out_wr_en);

  a_r10_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> !out_wr_en);

  a_r10_bad_height: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_form == 2'd0 && in_instr[36:35] == 2'd3 |=> out_err);

  a_r6_no_err_other_forms: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_form != 2'd0 |=> !out_err);

endmodule

bind tri_add_unit tri_add_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_instr   (in_instr),
  .in_form    (in_form),
  .in_guard   (in_guard),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_dst    (out_dst),
  .out_result (out_result),
  .out_wr_en  (out_wr_en),
  .out_err    (out_err)
);

// File: tb/tri_add_unit_tb_top.sv
module tri_add_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0]  dst;
    logic [31:0] res;
    logic        wr;
    logic        err;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_instr = '0;
  logic [1:0]  in_form = '0;
  logic [31:0] in_opa = '0, in_opb_reg = '0, in_opb_cbuf = '0, in_opc = '0;
  logic        in_guard = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_dst;
  logic [31:0] out_result;
  logic        out_wr_en;
  logic        out_err;

  int n_vec = 0;
  int n_bad = 0;
  bit bp_en = 0;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_add_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_form(in_form), .in_opa(in_opa),
    .in_opb_reg(in_opb_reg), .in_opb_cbuf(in_opb_cbuf), .in_opc(in_opc),
    .in_guard(in_guard), .out_valid(out_valid), .out_ready(out_ready),
    .out_dst(out_dst), .out_result(out_result), .out_wr_en(out_wr_en),
    .out_err(out_err)
  );

  function automatic logic [31:0] shape(logic [31:0] v, logic [1:0] h, logic n, bit rr);
    logic [31:0] t;
    t = v;
    if (rr && h == 2'd1) t = v & 32'h0000_FFFF;
    if (rr && h == 2'd2) t = v >> 16;
    return n ? (32'd0 - t) : t;
  endfunction

  function automatic logic [63:0] mk(logic [7:0] dst, logic [1:0] md,
      logic [1:0] ha, logic [1:0] hb, logic [1:0] hc, logic na, logic nb, logic nc);
    logic [63:0] w;
    w = '0;
    w[7:0] = dst; w[38:37] = md;
    w[36:35] = ha; w[34:33] = hb; w[32:31] = hc;
    w[51] = na; w[50] = nb; w[49] = nc;
    return w;
  endfunction

  task automatic send(string tag, logic [63:0] ins, logic [1:0] form,
      logic [31:0] a, logic [31:0] br, logic [31:0] bc, logic [31:0] c, logic g);
    item_t e;
    logic [31:0] b, s;
    bit rr;
    bit ok;
    rr = (form == 2'd0);
    b = (form == 2'd0) ? br : (form == 2'd1) ? bc
        : {{13{ins[56]}}, ins[38:20]};
    s = shape(a, ins[36:35], ins[51], rr) + shape(b, ins[34:33], ins[50], rr);
    if (rr && ins[38:37] == 2'd1) s = s >> 16;
    if (rr && ins[38:37] == 2'd2) s = s << 16;
    s = s + shape(c, ins[32:31], ins[49], rr);
    e.dst = ins[7:0];
    e.res = s;
    e.err = rr && (ins[36:35] == 2'd3 || ins[34:33] == 2'd3 || ins[32:31] == 2'd3);
    e.wr  = g && !e.err;
    e.tag = tag;
    in_valid = 1'b1; in_instr = ins; in_form = form; in_opa = a;
    in_opb_reg = br; in_opb_cbuf = bc; in_opc = c; in_guard = g;
    ok = 0;
    while (!ok) begin
      ok = in_ready;
      if (ok) sb.push_back(e);
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // Consumer ready: changes just after a rising edge, stable until the next one
  initial begin
    forever begin
      @(posedge clk);
      #1 out_ready = bp_en ? 1'($urandom % 2) : 1'b1;
    end
  end

  // Monitor: a transfer completes at the next edge when both are high here
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        item_t e;
        n_vec++;
        if (sb.size() == 0) begin
          n_bad++;
          $display("FAIL R11 unexpected output dst=%0h res=%08h expected none", out_dst, out_result);
        end else begin
          e = sb.pop_front();
          if (out_dst !== e.dst || out_wr_en !== e.wr || out_err !== e.err ||
              (!e.err && out_result !== e.res)) begin
            n_bad++;
            $display("FAIL %s dst=%0h res=%08h wr=%0b err=%0b expected dst=%0h res=%08h wr=%0b err=%0b",
                     e.tag, out_dst, out_result, out_wr_en, out_err, e.dst, e.res, e.wr, e.err);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired, %0d items outstanding expected 0", sb.size());
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] w;
    repeat (3) @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 in reset out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 idle out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end

    // R2 plain sums, including wrap
    send("R2 plain", mk(8'h05,0,0,0,0,0,0,0), 0, 32'h1234_5678, 32'h1111_1111, 32'h0, 32'h0101_0101, 1);
    send("R2 wrap", mk(8'h06,0,0,0,0,0,0,0), 0, 32'hFFFF_FFFF, 32'h2, 32'h0, 32'hFFFF_FFFF, 1);
    // R3 negation per operand
    send("R3 negA", mk(8'h10,0,0,0,0,1,0,0), 0, 32'h0000_0100, 32'h0000_1000, 32'h0, 32'h7, 1);
    send("R3 negB", mk(8'h11,0,0,0,0,0,1,0), 0, 32'h0000_0100, 32'h0000_1000, 32'h0, 32'h7, 1);
    send("R3 negC", mk(8'h12,0,0,0,0,0,0,1), 0, 32'h0000_0100, 32'h0000_1000, 32'h0, 32'h7, 1);
    send("R3 negAll", mk(8'h13,0,0,0,0,1,1,1), 0, 32'h3, 32'h5, 32'h0, 32'h9, 1);
    // R4 heights
    send("R4 loA", mk(8'h20,0,1,0,0,0,0,0), 0, 32'hABCD_1234, 32'h1, 32'h0, 32'h0, 1);
    send("R4 hiA", mk(8'h21,0,2,0,0,0,0,0), 0, 32'hABCD_1234, 32'h1, 32'h0, 32'h0, 1);
    send("R4 hiB", mk(8'h22,0,0,2,0,0,0,0), 0, 32'h1, 32'h8765_4321, 32'h0, 32'h0, 1);
    send("R4 loC", mk(8'h23,0,0,0,1,0,0,0), 0, 32'h1, 32'h1, 32'h0, 32'hFEDC_BA98, 1);
    send("R3 R4 neg after hi", mk(8'h24,0,2,0,0,1,0,0), 0, 32'h8000_0000, 32'h0, 32'h0, 32'h0, 1);
    // R5 modes
    for (int m = 0; m < 4; m++)
      send("R5 mode", mk(8'h30 + 8'(m), 2'(m),0,0,0,0,0,0), 0, 32'h1234_5678, 32'h0001_0001, 32'h0, 32'h0000_0010, 1);
    send("R5 split", mk(8'h34,2,1,1,2,0,0,0), 0, 32'h0003_0005, 32'h0004_0006, 32'h0, 32'h0007_0008, 1);
    // R6 / R7 constant-buffer and immediate forms ignore heights and mode
    send("R6 R7 cbuf", mk(8'h40,1,2,1,2,0,0,0), 1, 32'h1234_5678, 32'hDEAD, 32'h0002_0000, 32'h0000_0300, 1);
    send("R6 cbuf h3", mk(8'h41,2,3,3,3,0,1,0), 1, 32'h10, 32'h0, 32'h5, 32'h20, 1);
    w = mk(8'h42,0,0,0,0,0,0,0); w[38:20] = 19'h7FFFF; w[56] = 1'b0;
    send("R6 R7 imm pos", w, 2, 32'h100, 32'hDEAD, 32'hBEEF, 32'h1, 1);
    w = mk(8'h43,0,0,0,0,0,0,0); w[38:20] = 19'h00010; w[56] = 1'b1;
    send("R6 R7 imm neg", w, 3, 32'h100, 32'hDEAD, 32'hBEEF, 32'h1, 1);
    w = mk(8'h44,0,0,0,0,0,1,0); w[38:20] = 19'h00005;
    send("R3 R7 imm negated", w, 2, 32'h100, 32'h0, 32'h0, 32'h0, 1);
    // R8 destination field
    send("R8 dst ff", mk(8'hFF,0,0,0,0,0,0,0), 0, 32'h1, 32'h2, 32'h0, 32'h3, 1);
    // R9 guard
    send("R9 guard off", mk(8'h50,0,0,0,0,0,0,0), 0, 32'h11, 32'h22, 32'h0, 32'h33, 0);
    // R10 illegal heights
    send("R10 badA", mk(8'h60,0,3,0,0,0,0,0), 0, 32'h1, 32'h1, 32'h0, 32'h1, 1);
    send("R10 badB", mk(8'h61,0,0,3,0,0,0,0), 0, 32'h1, 32'h1, 32'h0, 32'h1, 1);
    send("R10 badC", mk(8'h62,0,0,0,3,0,0,0), 0, 32'h1, 32'h1, 32'h0, 32'h1, 0);
    send("R10 after bad", mk(8'h63,0,0,0,0,0,0,0), 0, 32'h4, 32'h4, 32'h0, 32'h4, 1);

    // R11 random stream under back-pressure
    bp_en = 1;
    for (int k = 0; k < 60; k++) begin
      w = {$urandom, $urandom};
      w[36:35] = (w[36:35] == 2'd3) ? 2'd1 : w[36:35];
      send("R11 stream", w, 2'($urandom), $urandom, $urandom, $urandom, $urandom, 1'($urandom));
    end
    bp_en = 0;
    for (int k = 0; k < 200 && sb.size() != 0; k++) @(negedge clk);
    n_vec++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R11 %0d results missing expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule